// File: doc/BRIEF.md
# Quadrature Encoder Index Latch Unit

This block tracks the position of a rotary or linear encoder from its two quadrature phases, A and B, and reacts to the once-per-revolution index channel N. Every legal A/B state change moves the position by a programmable fixed-point step. The step has a signed integer part and a fractional part. The fraction counts in units of 1/65536 or 1/10000, so gear ratios that are not powers of two can be followed without drift.

When a qualified index event arrives, the unit copies the current encoder position into a latch register. It can also capture an external ramp-generator position in the same cycle, and it can zero the encoder counter. A configuration word, loaded by a one-cycle write strobe, controls the following:
- the polarity of N;
- whether the A/B phase must match a programmed state;
- the kind of event: a level, or a transition in one or both directions;
- whether the action is armed for a single event or runs on every event.

Top module: `qei_index_latch`

## Requirements
- R1: Each legal A/B transition adds the step to the position, or subtracts it. Taking the state as {A,B}, the sequence 00→10→11→01→00 counts up and the reverse counts down. A transition that changes both bits in the same cycle leaves the position unchanged. A/B/N pass through two synchronizer flops, so the position is updated three clock edges after an input change.
- R2: With configuration bit 10 at 0 (binary fraction), the fractional accumulator wraps at 65536. On an up count the wrap carries one into the integer position. On a down count an underflow borrows one from it.
- R3: With configuration bit 10 at 1 (decimal fraction), the fractional accumulator wraps at 10000 instead, with the same carry and borrow rules.
- R4: Configuration bit 0 gives the active level of N: 1 means high is active and 0 means low is active.
- R5: Configuration bits 1 and 2 give the A and B levels that an index event requires. When bit 3 is 0, an event is qualified only while A and B match those levels. When bit 3 is 1, A and B are ignored.
- R6: Configuration bits [5:4] select the event type:
  - 00: the event repeats on every cycle the qualified condition holds;
  - 01: the event occurs when the condition becomes true;
  - 10: the event occurs when the condition becomes false;
  - 11: the event occurs on both transitions.
  A configuration write does not create a transition by itself.
- R7: When configuration bit 6 is set, a write arms one action. The first event after the write performs the action and consumes the arming. Later events do nothing until the next write.
- R8: When configuration bit 7 is set, every event performs the action.
- R9: When configuration bit 8 is set, the action also zeroes the integer and fractional position. The latch then holds the value from just before the clear. A count that arrives in the same cycle as the clear is dropped.
- R10: When configuration bit 9 is set, the action also copies ramp_pos into ramp_latch in the same cycle as the encoder latch. When bit 9 is clear, ramp_latch keeps its value.
- R11: After reset, enc_pos, enc_latch and ramp_latch are zero and no action is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Quadrature phase A (asynchronous) |
| enc_b | input | 1 | Quadrature phase B (asynchronous) |
| enc_n | input | 1 | Index channel (asynchronous) |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_wdata | input | 11 | Configuration word (fields as in R2–R10) |
| step_int | input | STEP_W | Signed integer part of the step |
| step_frac | input | FRAC_W | Fractional part of the step (below 10000 in decimal mode) |
| ramp_pos | input | POS_W | Ramp generator position to capture |
| enc_pos | output | POS_W | Integer encoder position |
| enc_latch | output | POS_W | Encoder position captured at the last action |
| ramp_latch | output | POS_W | Ramp position captured at the last enabled action |

## Verification
The bench builds the unit with its defaults:
- a 32-bit position;
- a 16-bit signed integer step;
- a 16-bit fraction;
- a decimal base of 10000.

With these widths, half-scale binary steps and a 6000/10000 decimal step reach a carry or a borrow within two counts. Each of the four event types is driven through the same N-rise, move, N-fall sequence, so the latched value shows in which cycles each type fired. The clear is also driven in the same cycle as an A edge, to confirm that the count is dropped.

// File: rtl/qei_pkg.sv
package qei_pkg;

    typedef enum logic [1:0] {
        EDGE_LEVEL    = 2'b00,
        EDGE_ACTIVE   = 2'b01,
        EDGE_INACTIVE = 2'b10,
        EDGE_BOTH     = 2'b11
    } edge_mode_e;

    // Packed MSB first: bit 10 down to bit 0.
    typedef struct packed {
        logic       dec_frac;   // 10
        logic       ramp_cap;   // 9
        logic       clr_en;     // 8
        logic       run_cont;   // 7
        logic       arm_once;   // 6
        edge_mode_e edge_mode;  // 5:4
        logic       ab_bypass;  // 3
        logic       b_req;      // 2
        logic       a_req;      // 1
        logic       n_high;     // 0
    } qei_cfg_t;

    localparam int CFG_W = $bits(qei_cfg_t);

    typedef enum logic [1:0] {
        Q_NONE,
        Q_UP,
        Q_DOWN,
        Q_ILLEGAL
    } quad_step_e;

    // Index condition from a configuration and the synchronized pins.
    function automatic logic index_qual(qei_cfg_t c, logic a, logic b, logic n);
        logic n_ok;
        logic ab_ok;
        n_ok  = (n == c.n_high);
        ab_ok = c.ab_bypass || ((a == c.a_req) && (b == c.b_req));
        return n_ok && ab_ok;
    endfunction

    // Classify an {A,B} state change; up order is 00,10,11,01.
    function automatic quad_step_e quad_classify(logic [1:0] prv, logic [1:0] cur);
        if (prv == cur) return Q_NONE;
        if ((prv ^ cur) == 2'b11) return Q_ILLEGAL;
        case ({prv, cur})
            4'b00_10, 4'b10_11, 4'b11_01, 4'b01_00: return Q_UP;
            default: return Q_DOWN;
        endcase
    endfunction

endpackage

// File: rtl/qei_sync.sv
module qei_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/qei_decoder.sv
module qei_decoder
    import qei_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] ab_s,
    output logic       cnt_up,
    output logic       cnt_dn
);
    logic [1:0] prev_q;
    quad_step_e cls;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 2'b00;
        else     prev_q <= ab_s;
    end

    always_comb begin
        cls    = quad_classify(prev_q, ab_s);
        cnt_up = (cls == Q_UP);
        cnt_dn = (cls == Q_DOWN);
    end

    // R1: a double-bit jump produces no count
    assert_illegal_ignored_R1: assert property (@(posedge clk) disable iff (rst)
        ((ab_s ^ prev_q) == 2'b11) |-> !(cnt_up || cnt_dn));

endmodule

// File: rtl/qei_index_detect.sv
module qei_index_detect
    import qei_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  qei_cfg_t cfg_q,
    input  logic     cfg_load,
    input  qei_cfg_t cfg_next,
    input  logic     a_s,
    input  logic     b_s,
    input  logic     n_s,
    output logic     evt
);
    logic     qual_now;
    logic     qual_q;
    qei_cfg_t cfg_track;

    // On a write, the history follows the new word, so the write itself forms no edge.
    assign cfg_track = cfg_load ? cfg_next : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) qual_q <= 1'b0;
        else     qual_q <= index_qual(cfg_track, a_s, b_s, n_s);
    end

    always_comb begin
        qual_now = index_qual(cfg_q, a_s, b_s, n_s);
        case (cfg_q.edge_mode)
            EDGE_LEVEL:    evt = qual_now;
            EDGE_ACTIVE:   evt = qual_now && !qual_q;
            EDGE_INACTIVE: evt = !qual_now && qual_q;
            default:       evt = qual_now ^ qual_q;
        endcase
    end

    // R4: a level-mode event implies N at its configured active level
    assert_level_polarity_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.edge_mode == EDGE_LEVEL && evt) |-> (n_s == cfg_q.n_high));

    // R5: without bypass, a level-mode event implies the required A/B phase
    assert_ab_match_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.edge_mode == EDGE_LEVEL && evt && !cfg_q.ab_bypass)
            |-> (a_s == cfg_q.a_req && b_s == cfg_q.b_req));

endmodule

// File: rtl/qei_accum.sv
module qei_accum #(
    parameter int POS_W    = 32,
    parameter int STEP_W   = 16,
    parameter int FRAC_W   = 16,
    parameter int DEC_BASE = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_up,
    input  logic              cnt_dn,
    input  logic              clr,
    input  logic              dec_mode,
    input  logic [STEP_W-1:0] step_int,
    input  logic [FRAC_W-1:0] step_frac,
    output logic [POS_W-1:0]  pos_int
);
    localparam int FW1 = FRAC_W + 1;
    localparam logic [FW1-1:0] BIN_MOD = FW1'(1) << FRAC_W;
    localparam logic [FW1-1:0] DEC_MOD = FW1'(DEC_BASE);

    logic [FRAC_W-1:0] frac_q;
    logic [FW1-1:0]    modv;
    logic [FW1-1:0]    sum_up;
    logic [FW1-1:0]    sum_dn;
    logic [FRAC_W-1:0] frac_nx;
    logic              wrap;
    logic [POS_W-1:0]  step_ext;
    logic [POS_W-1:0]  wrap_ext;
    logic [POS_W-1:0]  int_nx;

    assign modv     = dec_mode ? DEC_MOD : BIN_MOD;
    assign step_ext = {{(POS_W-STEP_W){step_int[STEP_W-1]}}, step_int};
    assign wrap_ext = {{(POS_W-1){1'b0}}, wrap};

    always_comb begin
        sum_up  = {1'b0, frac_q} + {1'b0, step_frac};
        sum_dn  = {1'b0, frac_q} + modv - {1'b0, step_frac};
        frac_nx = frac_q;
        wrap    = 1'b0;
        int_nx  = pos_int;
        if (cnt_up) begin
            wrap    = (sum_up >= modv);
            frac_nx = wrap ? FRAC_W'(sum_up - modv) : FRAC_W'(sum_up);
            int_nx  = pos_int + step_ext + wrap_ext;
        end else if (cnt_dn) begin
            wrap    = (frac_q < step_frac);
            frac_nx = wrap ? FRAC_W'(sum_dn) : (frac_q - step_frac);
            int_nx  = pos_int - step_ext - wrap_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_int <= '0;
            frac_q  <= '0;
        end else begin
            pos_int <= int_nx;
            frac_q  <= frac_nx;
        end
    end

    // R9: a clear zeroes both parts, even with a count in the same cycle
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pos_int == '0 && frac_q == '0));

    // R1: with no count and no clear the position holds
    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !(cnt_up || cnt_dn || clr) |=> $stable(pos_int) && $stable(frac_q));

    // R3: in decimal mode, starting from a legal fraction, the result stays below the base
    assert_dec_range_R3: assert property (@(posedge clk) disable iff (rst)
        (dec_mode && frac_q < DEC_MOD && step_frac < DEC_MOD) |=> (frac_q < DEC_MOD));

endmodule

// File: rtl/qei_index_latch.sv
module qei_index_latch
    import qei_pkg::*;
#(
    parameter int POS_W    = 32,
    parameter int STEP_W   = 16,
    parameter int FRAC_W   = 16,
    parameter int DEC_BASE = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [STEP_W-1:0] step_int,
    input  logic [FRAC_W-1:0] step_frac,
    input  logic [POS_W-1:0]  ramp_pos,
    output logic [POS_W-1:0]  enc_pos,
    output logic [POS_W-1:0]  enc_latch,
    output logic [POS_W-1:0]  ramp_latch
);
    qei_cfg_t   cfg_q;
    qei_cfg_t   cfg_new;
    logic [2:0] pins_s;
    logic       cnt_up;
    logic       cnt_dn;
    logic       evt;
    logic       armed_q;
    logic       act;
    logic       clr;

    assign cfg_new = qei_cfg_t'(cfg_wdata);

    qei_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({enc_n, enc_b, enc_a}),
        .q   (pins_s)
    );

    qei_decoder u_dec (
        .clk    (clk),
        .rst    (rst),
        .ab_s   ({pins_s[0], pins_s[1]}),
        .cnt_up (cnt_up),
        .cnt_dn (cnt_dn)
    );

    qei_index_detect u_idx (
        .clk      (clk),
        .rst      (rst),
        .cfg_q    (cfg_q),
        .cfg_load (cfg_wr),
        .cfg_next (cfg_new),
        .a_s      (pins_s[0]),
        .b_s      (pins_s[1]),
        .n_s      (pins_s[2]),
        .evt      (evt)
    );

    assign act = evt && (armed_q || cfg_q.run_cont);
    assign clr = act && cfg_q.clr_en;

    qei_accum #(
        .POS_W    (POS_W),
        .STEP_W   (STEP_W),
        .FRAC_W   (FRAC_W),
        .DEC_BASE (DEC_BASE)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .cnt_up    (cnt_up),
        .cnt_dn    (cnt_dn),
        .clr       (clr),
        .dec_mode  (cfg_q.dec_frac),
        .step_int  (step_int),
        .step_frac (step_frac),
        .pos_int   (enc_pos)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            armed_q <= 1'b0;
        end else if (cfg_wr) begin
            cfg_q   <= cfg_new;
            armed_q <= cfg_new.arm_once;
        end else if (act) begin
            armed_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_latch  <= '0;
            ramp_latch <= '0;
        end else if (act) begin
            enc_latch <= enc_pos;
            if (cfg_q.ramp_cap) ramp_latch <= ramp_pos;
        end
    end

    // R9: the latch receives the position from before any clear
    assert_latch_capture_R9: assert property (@(posedge clk) disable iff (rst)
        act |=> (enc_latch == $past(enc_pos)));

    // R8: without an action the latch holds
    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !act |=> $stable(enc_latch));

    // R7: one action consumes the single-shot arming
    assert_once_consumed_R7: assert property (@(posedge clk) disable iff (rst)
        (act && !cfg_wr) |=> !armed_q);

    // R10: ramp capture follows the enable bit
    assert_ramp_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (act && cfg_q.ramp_cap) |=> (ramp_latch == $past(ramp_pos)));

    assert_ramp_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(act && cfg_q.ramp_cap) |=> $stable(ramp_latch));

endmodule

// File: tb/qei_index_latch_tb.sv
module qei_index_latch_tb;
    localparam int POS_W  = 32;
    localparam int STEP_W = 16;
    localparam int FRAC_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enc_a = 1'b0, enc_b = 1'b0, enc_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [10:0]       cfg_wdata = '0;
    logic [STEP_W-1:0] step_int = '0;
    logic [FRAC_W-1:0] step_frac = '0;
    logic [POS_W-1:0]  ramp_pos = '0;
    logic [POS_W-1:0]  enc_pos, enc_latch, ramp_latch;

    always #2.5 clk = ~clk;

    qei_index_latch u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_n(enc_n),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .step_int(step_int),
        .step_frac(step_frac), .ramp_pos(ramp_pos),
        .enc_pos(enc_pos), .enc_latch(enc_latch), .ramp_latch(ramp_latch)
    );

    typedef struct {
        string       req;
        logic [31:0] pos;
        logic [31:0] lat;
        logic [31:0] rmp;
    } exp_item_t;

    exp_item_t sb_q[$];
    exp_item_t it;
    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Bench-side model state
    int m_int = 0, m_frac = 0, m_latch = 0, m_ramp = 0, phase = 0;
    bit m_dec = 0;

    // Monitor: pop expectations and compare against the ports.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            vectors += 3;
            if (enc_pos !== it.pos) begin
                errors++;
                $display("FAIL %s enc_pos actual=%0d expected=%0d", it.req, enc_pos, it.pos);
            end
            if (enc_latch !== it.lat) begin
                errors++;
                $display("FAIL %s enc_latch actual=%0d expected=%0d", it.req, enc_latch, it.lat);
            end
            if (ramp_latch !== it.rmp) begin
                errors++;
                $display("FAIL %s ramp_latch actual=%0h expected=%0h", it.req, ramp_latch, it.rmp);
            end
        end
    end

    task automatic expect_now(string req);
        exp_item_t e;
        e.req = req;
        e.pos = 32'(m_int);
        e.lat = 32'(m_latch);
        e.rmp = 32'(m_ramp);
        sb_q.push_back(e);
        repeat (2) @(negedge clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    function automatic logic [10:0] mk(bit nh, bit ar, bit br, bit byp, logic [1:0] em,
                                       bit once, bit cont, bit clr, bit rc, bit dec);
        return {dec, rc, clr, cont, once, em, byp, br, ar, nh};
    endfunction

    task automatic wr_cfg(logic [10:0] w);
        @(negedge clk);
        cfg_wdata = w;
        cfg_wr    = 1'b1;
        @(negedge clk);
        cfg_wr    = 1'b0;
        m_dec     = w[10];
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [1:0] gray(int p);
        case (p)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    function automatic void model_step(bit up);
        int md = m_dec ? 10000 : 65536;
        int si = int'($signed(step_int));
        int sf = int'(step_frac);
        if (up) begin
            m_frac += sf;
            if (m_frac >= md) begin m_frac -= md; m_int += si + 1; end
            else m_int += si;
        end else begin
            if (m_frac >= sf) begin m_frac -= sf; m_int -= si; end
            else begin m_frac = m_frac + md - sf; m_int -= si + 1; end
        end
    endfunction

    // Drive one quadrature step; no_wait lets the caller pair it with an N change.
    task automatic quad(bit up, bit no_wait = 0);
        phase = up ? (phase + 1) % 4 : (phase + 3) % 4;
        {enc_a, enc_b} = gray(phase);
        model_step(up);
        if (!no_wait) settle();
    endtask

    task automatic pulse_n_high();
        enc_n = 1'b1; settle();
        enc_n = 1'b0; settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        expect_now("R11 reset state");

        // R1: integer steps, both directions, illegal jump
        step_int = 16'd3; step_frac = '0;
        for (int i = 0; i < 4; i++) quad(1);
        expect_now("R1 four up counts");
        quad(0); quad(0);
        expect_now("R1 two down counts");
        phase = (phase + 2) % 4;
        {enc_a, enc_b} = gray(phase);
        settle();
        expect_now("R1 illegal double-bit change ignored");
        quad(1);
        expect_now("R1 count resumes after illegal change");

        // R2: binary fraction carry and borrow
        step_int = 16'd0; step_frac = 16'h8000;
        quad(1); quad(1);
        expect_now("R2 binary carry into integer");
        quad(0);
        expect_now("R2 binary borrow from integer");
        quad(0);

        // R3: decimal fraction, base 10000
        wr_cfg(mk(0,0,0,0,2'b00,0,0,0,0,1));
        step_int = 16'd1; step_frac = 16'd6000;
        quad(1); quad(1);
        expect_now("R3 decimal carry at 10000");
        quad(1); quad(0); quad(0);
        expect_now("R3 decimal borrow");
        step_frac = '0;
        wr_cfg(mk(0,0,0,0,2'b00,0,0,0,0,0));

        // R6: the four event types through rise, move, fall
        for (int md = 0; md < 4; md++) begin
            int p1, p2;
            wr_cfg(mk(1,0,0,1,2'(md),0,1,0,0,0));
            enc_n = 1'b1; settle();
            p1 = m_int;
            if (md == 0 || md == 1 || md == 3) m_latch = p1;
            expect_now($sformatf("R6 mode %0d after N active", md));
            quad(1);
            p2 = m_int;
            if (md == 0) m_latch = p2;
            expect_now($sformatf("R6 mode %0d after move while active", md));
            enc_n = 1'b0; settle();
            if (md == 2 || md == 3) m_latch = p2;
            expect_now($sformatf("R6 mode %0d after N inactive", md));
            wr_cfg('0);
        end

        // R4: active-low index
        enc_n = 1'b1; settle();
        wr_cfg(mk(0,0,0,1,2'b01,0,1,0,0,0));
        enc_n = 1'b0; settle();
        m_latch = m_int;
        expect_now("R4 active-low N falling edge latches");
        quad(1);
        enc_n = 1'b1; settle();
        expect_now("R4 N rising edge is inactive-going");
        wr_cfg('0);
        enc_n = 1'b0; settle();

        // R5: A/B qualification and bypass
        wr_cfg(mk(1,1,1,0,2'b01,0,1,0,0,0));
        quad(1);
        while (phase != 0) quad(1);
        pulse_n_high();
        expect_now("R5 A/B mismatch blocks event");
        quad(1); quad(1);
        pulse_n_high();
        m_latch = m_int;
        expect_now("R5 A/B match permits event");
        wr_cfg(mk(1,1,1,1,2'b01,0,1,0,0,0));
        quad(1); quad(1);
        pulse_n_high();
        m_latch = m_int;
        expect_now("R5 bypass ignores A/B");
        wr_cfg('0);

        // R7: single-shot arming
        wr_cfg(mk(1,0,0,1,2'b01,1,0,0,0,0));
        pulse_n_high();
        m_latch = m_int;
        expect_now("R7 first event after write latches");
        quad(1);
        pulse_n_high();
        expect_now("R7 second event ignored");
        wr_cfg(mk(1,0,0,1,2'b01,1,0,0,0,0));
        quad(1);
        pulse_n_high();
        m_latch = m_int;
        expect_now("R7 rewrite re-arms");

        // R8: continuous
        wr_cfg(mk(1,0,0,1,2'b01,0,1,0,0,0));
        pulse_n_high();
        m_latch = m_int;
        expect_now("R8 continuous first event");
        quad(1);
        pulse_n_high();
        m_latch = m_int;
        expect_now("R8 continuous second event");

        // R9: latch and clear
        wr_cfg(mk(1,0,0,1,2'b01,0,1,1,0,0));
        pulse_n_high();
        m_latch = m_int; m_int = 0; m_frac = 0;
        expect_now("R9 clear zeroes counter, latch keeps old value");
        quad(1); quad(1);
        enc_n = 1'b1;
        quad(1, 1);
        m_int = 0; m_latch = 2;
        settle();
        expect_now("R9 count in clear cycle dropped");
        enc_n = 1'b0; settle();
        quad(1);
        expect_now("R9 counting resumes after clear");

        // R10: ramp capture
        ramp_pos = 32'h1234_5678;
        wr_cfg(mk(1,0,0,1,2'b01,0,1,0,1,0));
        pulse_n_high();
        m_latch = m_int; m_ramp = 32'h1234_5678;
        expect_now("R10 ramp captured with encoder");
        ramp_pos = 32'h0BAD_F00D;
        wr_cfg(mk(1,0,0,1,2'b01,0,1,0,0,0));
        quad(1);
        pulse_n_high();
        m_latch = m_int;
        expect_now("R10 ramp latch holds when disabled");

        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule